// File: doc/BRIEF.md
# Quadrature pulse train generator

This block plays out a commanded move as a quadrature encoder signal pair (A and B) with an index output. A host pushes each move as four words into a small command FIFO through a valid/ready port. The words are, in this order: the number of quadrature edges, the spacing between edges in system clocks, the edge number at which index rises and the edge number at which index falls.

A loader pulls the four words. While it loads, it holds an internal halt/clear signal high and drives the done flag low. Once all words are in, it clears the interval counter, pulses a load-complete event and releases halt. Generation then runs until the loaded edge count is reached. At that point done rises and a move-complete event pulses. If done is already high when halt is released (a zero-edge move), no edges are emitted and a halt latch is set instead. Words that arrive while a move is running stay queued until done is high.

Top module: `qpt_gen`

## Requirements
- R1: After reset, done is 1, A, B and index are 0, the halt latch and both events are 0, and cmd_ready is 1.
- R2: The loader consumes each move as four FIFO words in this order: edge count, spacing S, index-rise edge number, index-fall edge number.
- R3: The first edge of a move appears S+2 clocks after the clock in which load_evt is seen high. Each later edge follows the one before it by exactly S+1 clocks.
- R4: A move with edge count N emits exactly N edges. Done rises with the N-th edge, and no edge appears while done is high.
- R5: A move with edge count 0 emits no edges and keeps done high. It sets the halt latch when halt is released.
- R6: The halt latch is cleared when the next load starts, and a move with a nonzero count leaves it at 0.
- R7: Index rises at the edge whose 1-based number equals the rise value and falls at the edge whose number equals the fall value. Fall wins if both match the same edge. Index is also cleared when a load starts.
- R8: A rise value of 16'hFFFF (all ones) keeps index at 0 for the whole move.
- R9: load_evt pulses for exactly one clock per loaded move. move_evt pulses for exactly one clock each time done rises.
- R10: With dir=0, each edge steps {A,B} forward through 00, 01, 11, 10. With dir=1, each edge steps it backward through 00, 10, 11, 01. The phase carries over from one move to the next.
- R11: Words pushed during a running move do not change that move. They are consumed only after done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_data | input | W | Command word |
| cmd_ready | output | 1 | FIFO can accept a word |
| dir | input | 1 | 0 forward, 1 reverse phase order |
| qa | output | 1 | Quadrature A |
| qb | output | 1 | Quadrature B |
| qidx | output | 1 | Index output |
| done | output | 1 | Move finished / idle |
| halt_latch | output | 1 | Set when release found done high |
| load_evt | output | 1 | One-clock pulse: all move words loaded |
| move_evt | output | 1 | One-clock pulse: done rose |

## Verification
The bench times every edge against load_evt. If the interval counter were not cleared before release, or if it counted while halted, the first edge would land early or late. It counts edges up to done. An off-by-one compare in the final-edge detection would emit one edge too many or too few, or would raise done on the wrong sample. A zero-edge move checks that done stays high and the latch sets; a wrong latch condition would leave it clear or set it on ordinary moves. Index placement is checked at each edge, including the all-ones rise value. A second move is pushed while the first is running, so an early pop would corrupt the first move's count or spacing.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_CNT,
    LD_SPC,
    LD_RISE,
    LD_FALL,
    LD_REL
  } ld_state_t;

  // phase 0..3 to {A,B} Gray pattern
  function automatic logic [1:0] phase_to_ab(input logic [1:0] ph);
    return {ph[1], ph[1] ^ ph[0]};
  endfunction

endpackage

// File: rtl/qpt_fifo.sv
module qpt_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic [W-1:0] out_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = DEPTH[AW:0];

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          push;

  assign in_ready = (cnt_q != FULL);
  assign empty    = (cnt_q == '0);
  assign push     = in_valid & in_ready;
  assign out_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rp_d = rp_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= in_data;
  end
endmodule

// File: rtl/qpt_loader.sv
module qpt_loader
  import qpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         f_empty,
  input  logic [W-1:0] f_data,
  input  logic         done,
  output logic         pop,
  output logic         halt,
  output logic         clr_iv,
  output logic         load_evt,
  output logic         start_load,
  output logic         zero_cnt,
  output logic         halt_latch,
  output logic [W-1:0] cfg_cnt,
  output logic [W-1:0] cfg_spc,
  output logic [W-1:0] cfg_rise,
  output logic [W-1:0] cfg_fall
);
  ld_state_t st_q, st_d;
  logic      latch_d;

  always_comb begin
    st_d       = st_q;
    pop        = 1'b0;
    start_load = 1'b0;
    unique case (st_q)
      LD_IDLE: if (!f_empty && done) begin
        start_load = 1'b1;
        st_d       = LD_CNT;
      end
      LD_CNT:  if (!f_empty) begin pop = 1'b1; st_d = LD_SPC;  end
      LD_SPC:  if (!f_empty) begin pop = 1'b1; st_d = LD_RISE; end
      LD_RISE: if (!f_empty) begin pop = 1'b1; st_d = LD_FALL; end
      LD_FALL: if (!f_empty) begin pop = 1'b1; st_d = LD_REL;  end
      LD_REL:  st_d = LD_IDLE;
      default: st_d = LD_IDLE;
    endcase
  end

  assign halt     = (st_q != LD_IDLE);
  assign clr_iv   = (st_q == LD_REL);
  assign load_evt = (st_q == LD_REL);
  assign zero_cnt = pop && (st_q == LD_CNT) && (f_data == '0);

  always_comb begin
    latch_d = halt_latch;
    if (start_load) latch_d = 1'b0;
    else if ((st_q == LD_REL) && done) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= LD_IDLE;
      halt_latch <= 1'b0;
      cfg_cnt    <= '0;
      cfg_spc    <= '0;
      cfg_rise   <= '0;
      cfg_fall   <= '0;
    end else begin
      st_q       <= st_d;
      halt_latch <= latch_d;
      if (pop && st_q == LD_CNT)  cfg_cnt  <= f_data;
      if (pop && st_q == LD_SPC)  cfg_spc  <= f_data;
      if (pop && st_q == LD_RISE) cfg_rise <= f_data;
      if (pop && st_q == LD_FALL) cfg_fall <= f_data;
    end
  end
endmodule

// File: rtl/qpt_interval.sv
module qpt_interval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] spacing,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         hit;

  assign hit  = (cnt_q == spacing);
  assign tick = run & hit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qpt_edge.sv
module qpt_edge
  import qpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start_load,
  input  logic         zero_cnt,
  input  logic         dir,
  input  logic [W-1:0] cfg_cnt,
  input  logic [W-1:0] cfg_rise,
  input  logic [W-1:0] cfg_fall,
  output logic         done,
  output logic         qa,
  output logic         qb,
  output logic         qidx,
  output logic         move_evt
);
  localparam logic [W-1:0] NEVER = '1;

  logic [W-1:0] ecnt_q, ecnt_d, nxt;
  logic [1:0]   ph_q, ph_d;
  logic         done_d, done_prev, idx_d, last;

  assign nxt  = ecnt_q + 1'b1;
  assign last = tick && (nxt == cfg_cnt);

  always_comb begin
    ecnt_d = ecnt_q;
    done_d = done;
    ph_d   = ph_q;
    idx_d  = qidx;
    if (start_load) begin
      ecnt_d = '0;
      done_d = 1'b0;
      idx_d  = 1'b0;
    end else if (zero_cnt) begin
      done_d = 1'b1;
    end else if (tick) begin
      ph_d   = dir ? ph_q - 1'b1 : ph_q + 1'b1;
      ecnt_d = last ? '0 : nxt;
      if (last) done_d = 1'b1;
      if (nxt == cfg_fall) idx_d = 1'b0;
      else if (nxt == cfg_rise && cfg_rise != NEVER) idx_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q    <= '0;
      done      <= 1'b1;
      done_prev <= 1'b1;
      ph_q      <= '0;
      qidx      <= 1'b0;
    end else begin
      ecnt_q    <= ecnt_d;
      done      <= done_d;
      done_prev <= done;
      ph_q      <= ph_d;
      qidx      <= idx_d;
    end
  end

  assign {qa, qb}  = phase_to_ab(ph_q);
  assign move_evt  = done & ~done_prev;
endmodule

// File: rtl/qpt_gen.sv
module qpt_gen #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [W-1:0] cmd_data,
  output logic         cmd_ready,
  input  logic         dir,
  output logic         qa,
  output logic         qb,
  output logic         qidx,
  output logic         done,
  output logic         halt_latch,
  output logic         load_evt,
  output logic         move_evt
);
  logic         f_empty, pop, halt, clr_iv, start_load, zero_cnt, tick, run;
  logic [W-1:0] f_data, cfg_cnt, cfg_spc, cfg_rise, cfg_fall;

  assign run = ~halt & ~done;

  qpt_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid), .in_data(cmd_data),
    .in_ready(cmd_ready), .pop(pop), .out_data(f_data), .empty(f_empty)
  );

  qpt_loader #(.W(W)) u_load (
    .clk(clk), .rst_n(rst_n), .f_empty(f_empty), .f_data(f_data), .done(done),
    .pop(pop), .halt(halt), .clr_iv(clr_iv), .load_evt(load_evt),
    .start_load(start_load), .zero_cnt(zero_cnt), .halt_latch(halt_latch),
    .cfg_cnt(cfg_cnt), .cfg_spc(cfg_spc), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall)
  );

  qpt_interval #(.W(W)) u_iv (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_iv), .spacing(cfg_spc),
    .tick(tick)
  );

  qpt_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_load(start_load),
    .zero_cnt(zero_cnt), .dir(dir), .cfg_cnt(cfg_cnt), .cfg_rise(cfg_rise),
    .cfg_fall(cfg_fall), .done(done), .qa(qa), .qb(qb), .qidx(qidx),
    .move_evt(move_evt)
  );
endmodule

// File: rtl/qpt_gen_chk.sv
module qpt_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         qa,
  input logic         qb,
  input logic         qidx,
  input logic         done,
  input logic         halt_latch,
  input logic         load_evt,
  input logic         move_evt,
  input logic [W-1:0] cfg_rise
);
  // R4: no edge while done was high
  assert_no_edge_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> $stable({qa, qb}));

  // R10: one output bit changes at most per clock
  assert_single_bit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({qa, qb} ^ $past({qa, qb})) <= 1);

  // R9: load event lasts one clock
  assert_load_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);

  // R9: move event only on a rise of done
  assert_move_on_done_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    move_evt |-> (done && !$past(done)));

  // R5: latch sets only at release with done high
  assert_latch_at_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_latch) |-> (done && $past(load_evt)));

  // R8: all-ones rise keeps index low
  assert_index_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rise == '1) |-> !qidx);
endmodule

bind qpt_gen qpt_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .qa(qa), .qb(qb), .qidx(qidx), .done(done),
  .halt_latch(halt_latch), .load_evt(load_evt), .move_evt(move_evt),
  .cfg_rise(cfg_rise)
);

// File: tb/qpt_gen_test.sv
module qpt_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk, rst_n, cmd_valid, dir;
  logic [W-1:0] cmd_data;
  logic         cmd_ready, qa, qb, qidx, done, halt_latch, load_evt, move_evt;

  int total = 0, bad = 0;
  int lcnt = 0, mcnt = 0;
  int ph = 0;
  bit finished = 0;

  qpt_gen #(.W(W), .DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .dir(dir), .qa(qa), .qb(qb), .qidx(qidx),
    .done(done), .halt_latch(halt_latch), .load_evt(load_evt),
    .move_evt(move_evt)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (load_evt) lcnt++;
    if (move_evt) mcnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ab_of(input int p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic push_word(input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push_move(input logic [W-1:0] n, s, r, f);
    push_word(n); push_word(s); push_word(r); push_word(f);
  endtask

  // waits for load_evt of the next move and checks the whole move
  task automatic measure(input string tag, input int n, input int s,
                         input int r, input int f);
    int t = 0, k = 0, last_t = 0, lc0;
    bit sp_ok = 1, idx_ok = 1, ab_ok = 1, dn_ok = 1;
    int prev, cur, ex_idx;
    lc0 = lcnt;
    while (!load_evt) @(negedge clk);
    chk({tag, " R6 latch clear at load"}, halt_latch, 0);
    prev = {qa, qb};
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      cur = {qa, qb};
      if (cur != prev) begin
        k++;
        ph = dir ? (ph + 3) % 4 : (ph + 1) % 4;
        if (cur != ab_of(ph)) ab_ok = 0;
        if (k == 1) begin if (t != s + 2) sp_ok = 0; end
        else if (t - last_t != s + 1) sp_ok = 0;
        last_t = t;
        ex_idx = (r != 16'hFFFF && k >= r && k < f) ? 1 : 0;
        if (qidx != ex_idx) idx_ok = 0;
        if ((k == n) != done) dn_ok = 0;
        prev = cur;
      end
    end
    chk({tag, " R4 edge count"}, k, n);
    chk({tag, " R3 edge spacing"}, sp_ok, 1);
    chk({tag, " R7 R8 index placement"}, idx_ok, 1);
    chk({tag, " R10 phase order"}, ab_ok, 1);
    chk({tag, " R4 done with last edge"}, dn_ok, 1);
    chk({tag, " R9 one load pulse"}, lcnt - lc0, 1);
    @(negedge clk);
    chk({tag, " R6 latch stays clear"}, halt_latch, 0);
  endtask

  task automatic test_reset();
    chk("R1 done", done, 1);
    chk("R1 ab", {qa, qb}, 0);
    chk("R1 idx", qidx, 0);
    chk("R1 latch", halt_latch, 0);
    chk("R1 events", {load_evt, move_evt}, 0);
    chk("R1 ready", cmd_ready, 1);
  endtask

  task automatic test_forward();
    int m0 = mcnt;
    dir = 0;
    push_move(8, 2, 3, 6);
    measure("fwd R2", 8, 2, 3, 6);
    chk("R9 one move pulse fwd", mcnt - m0, 1);
  endtask

  task automatic test_reverse();
    dir = 1;
    push_move(5, 0, 1, 5);
    measure("rev R10", 5, 0, 1, 5);
  endtask

  task automatic test_zero();
    int ab0, m0 = mcnt, lc0 = lcnt;
    ab0 = {qa, qb};
    push_move(0, 3, 1, 2);
    while (!load_evt) @(negedge clk);
    chk("R5 done high during zero load", done, 1);
    repeat (3) @(negedge clk);
    chk("R5 latch set", halt_latch, 1);
    chk("R5 no edges", {qa, qb}, ab0);
    chk("R5 done stays", done, 1);
    chk("R9 load pulse zero", lcnt - lc0, 1);
    chk("R9 move pulse zero", mcnt - m0, 1);
  endtask

  task automatic test_after_zero();
    dir = 0;
    push_move(3, 4, 16'hFFFF, 2);
    measure("after zero R6 R8", 3, 4, 16'hFFFF, 2);
  endtask

  task automatic test_queued();
    dir = 0;
    push_move(5, 9, 2, 4);
    fork
      measure("run R11", 5, 9, 2, 4);
      begin
        repeat (10) @(negedge clk);
        push_move(4, 1, 1, 3);
      end
    join
    measure("queued R11", 4, 1, 1, 3);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_data = '0; dir = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_forward();
    test_reverse();
    test_zero();
    test_after_zero();
    test_queued();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule